// File: doc/BRIEF.md
# SDRAM Mode Register Load Sequencer

This block sits on the controller side of a DDR SDRAM and writes a new word into the memory's base mode register when asked. A single-cycle start pulse carries the request: a burst length code, a burst ordering flag, a CAS latency code and a DLL reset flag. The block checks the request first. It then drives a precharge-all command and holds idle cycles for the row precharge interval. Next it drives the mode register set command, with the request encoded on the address pins. Finally it holds idle cycles for the mode register set delay and pulses done.

A request that carries a reserved code is refused. The block raises an error flag and drives no command at all. All outputs are registered.

The block has no data stream, so there is no valid/ready interface. All its pins are plain control and status lines. A start pulse that arrives while busy is high is dropped. The caller waits for done, or for busy to fall, before it sends the next request.

Top module: `sdram_mode_loader`

## Requirements
- R1: While reset is held (active-low, synchronous), all four strobes are high (idle command), addr and ba are zero, and busy, done and err are low.
- R2: A legal start sampled while idle gives a precharge-all on the next cycle. In that cycle cs_n, ras_n and we_n are low, cas_n is high, addr[10] is 1, ba is 0, and busy is high.
- R3: The mode register set command comes exactly TRP_CYC cycles after the precharge-all, with all four strobes low. Every cycle between the two is idle (all strobes high).
- R4: In the mode register set cycle, addr[2:0] equals the burst length code, addr[3] the ordering flag (1 = interleave), addr[6:4] the CAS latency code and addr[8] the DLL reset flag. addr[7], addr[11:9] and ba are all zero.
- R5: After the mode register set command, the strobes stay idle until done. Done is a one-cycle pulse exactly max(TMRD_CYC,2) cycles after the mode register set cycle, so a TMRD_CYC of 1 behaves as 2.
- R6: Busy is high from the cycle after an accepted start through the cycle before done, and it is low in the done cycle.
- R7: A start pulse sampled while busy is ignored. The schedule in progress is unchanged, and no second precharge follows.
- R8: A CAS latency code other than 3'b011 is refused. On the next cycle err is high, busy is low, and the strobes stay idle.
- R9: Burst length codes 3'b000, 3'b100, 3'b101 and 3'b110 are refused, and so is code 3'b111 with interleave ordering. Each gives the same result as R8. Codes 3'b001, 3'b010 and 3'b011 are legal with either ordering, and 3'b111 is legal with sequential ordering.
- R10: Each start sampled while idle sets err to the refusal result of that request, so a legal request clears an earlier error. Reset also clears err.
- R11: The request is captured when start is sampled. Input changes after that cycle do not alter the word driven in the mode register set cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request pulse |
| req_blen | input | 3 | Burst length code |
| req_interleave | input | 1 | Burst ordering: 0 sequential, 1 interleave |
| req_cl | input | 3 | CAS latency code |
| req_dll_reset | input | 1 | DLL reset flag for the mode word |
| cs_n | output | 1 | Chip select strobe, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable strobe, active low |
| addr | output | ADDR_W (12) | Memory address pins |
| ba | output | BA_W (2) | Bank select pins |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request used a reserved code |

## Verification
The assertions assume that start and the request fields are synchronous to clk and settled at each rising edge. They also assume that start is sampled only as a level on that edge, so a start held high into a busy period simply counts as ignored. The bench drives every input on the falling edge and holds start for exactly one cycle, which keeps these assumptions true. For the ignored-start case it raises start again during busy and changes the fields at the same time. This tests the capture rule and the refusal rule without ever presenting an unsettled input.

// File: rtl/mode_loader_pkg.sv
package mode_loader_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_t CMD_PALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam cmd_t CMD_MSET = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  // bit positions decoded by the memory
  localparam int BLEN_LSB = 0;
  localparam int ORDER_BIT = 3;
  localparam int LAT_LSB = 4;
  localparam int TEST_BIT = 7;
  localparam int DLLR_BIT = 8;
  localparam int ALLBANK_BIT = 10;

  localparam logic [2:0] LAT_THREE = 3'b011;
  localparam logic [2:0] BLEN_FULL = 3'b111;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RP_WAIT,
    SEQ_MRD_WAIT
  } seq_state_t;

endpackage

// File: rtl/mode_word_encoder.sv
module mode_word_encoder
  import mode_loader_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        blen,
  input  logic              interleave,
  input  logic [2:0]        cl,
  input  logic              dll_reset,
  output logic              legal,
  output logic [ADDR_W-1:0] word
);

  logic blen_ok;

  always_comb begin
    unique case (blen)
      3'b001, 3'b010, 3'b011: blen_ok = 1'b1;
      BLEN_FULL:              blen_ok = ~interleave;
      default:                blen_ok = 1'b0;
    endcase
  end

  assign legal = blen_ok && (cl == LAT_THREE);

  always_comb begin
    word = '0;
    word[BLEN_LSB +: 3] = blen;
    word[ORDER_BIT]     = interleave;
    word[LAT_LSB +: 3]  = cl;
    word[TEST_BIT]      = 1'b0;
    word[DLLR_BIT]      = dll_reset;
  end

endmodule

// File: rtl/mode_wait_timer.sv
module mode_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R3: an expired count stays expired until reloaded
  p_timer_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);

  // R3: a load of a nonzero value is not expired on the next cycle
  p_timer_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !zero);

endmodule

// File: rtl/sdram_mode_loader.sv
module sdram_mode_loader
  import mode_loader_pkg::*;
#(
  parameter int TRP_CYC  = 3,
  parameter int TMRD_CYC = 2,
  parameter int ADDR_W   = 12,
  parameter int BA_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        req_blen,
  input  logic              req_interleave,
  input  logic [2:0]        req_cl,
  input  logic              req_dll_reset,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int TRP_EFF  = (TRP_CYC < 1) ? 1 : TRP_CYC;
  localparam int TMRD_EFF = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
  localparam int MAX_WAIT = (TRP_EFF > TMRD_EFF) ? TRP_EFF : TMRD_EFF;
  localparam int CNT_W    = $clog2(MAX_WAIT) + 1;
  localparam int SINCE_W  = CNT_W + 1;
  localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(TRP_EFF - 1);
  localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(TMRD_EFF - 1);

  seq_state_t        state_q;
  cmd_t              cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] word_q;
  logic              busy_q, done_q, err_q;

  logic              enc_legal;
  logic [ADDR_W-1:0] enc_word;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic              accept;

  mode_word_encoder #(.ADDR_W(ADDR_W)) u_enc (
    .blen       (req_blen),
    .interleave (req_interleave),
    .cl         (req_cl),
    .dll_reset  (req_dll_reset),
    .legal      (enc_legal),
    .word       (enc_word)
  );

  assign accept   = (state_q == SEQ_IDLE) && start && enc_legal;
  assign tmr_load = accept || ((state_q == SEQ_RP_WAIT) && tmr_zero);
  assign tmr_val  = (state_q == SEQ_IDLE) ? RP_LOAD : MRD_LOAD;

  mode_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cmd_q   <= CMD_IDLE;
      addr_q  <= '0;
      word_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      cmd_q  <= CMD_IDLE;
      addr_q <= '0;
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            err_q <= ~enc_legal;
            if (enc_legal) begin
              word_q              <= enc_word;
              cmd_q               <= CMD_PALL;
              addr_q[ALLBANK_BIT] <= 1'b1;
              busy_q              <= 1'b1;
              state_q             <= SEQ_RP_WAIT;
            end
          end
        end
        SEQ_RP_WAIT: begin
          if (tmr_zero) begin
            cmd_q   <= CMD_MSET;
            addr_q  <= word_q;
            state_q <= SEQ_MRD_WAIT;
          end
        end
        SEQ_MRD_WAIT: begin
          if (tmr_zero) begin
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr = addr_q;
  assign ba   = '0;
  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;

  // ---- assertions ----
  logic             pall_now, mset_now;
  logic [SINCE_W-1:0] since_pall, since_mset;

  assign pall_now = ({cs_n, ras_n, cas_n, we_n} == CMD_PALL);
  assign mset_now = ({cs_n, ras_n, cas_n, we_n} == CMD_MSET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pall <= '1;
      since_mset <= '1;
    end else begin
      if (pall_now)              since_pall <= SINCE_W'(1);
      else if (since_pall != '1) since_pall <= since_pall + 1'b1;
      if (mset_now)              since_mset <= SINCE_W'(1);
      else if (since_mset != '1) since_mset <= since_mset + 1'b1;
    end
  end

  // R2: legal request while idle gives precharge-all next cycle
  p_accept_pall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && enc_legal) |=> (pall_now && addr[ALLBANK_BIT] && busy));

  // R3: mode register set exactly TRP after precharge-all
  p_rp_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mset_now |-> (since_pall == SINCE_W'(TRP_EFF)));

  // R4: test bit and reserved high bits low in the mode register set cycle
  p_mset_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mset_now |-> (!addr[TEST_BIT] && addr[ADDR_W-1:9] == '0));

  // R5: no command inside the mode register set delay
  p_mrd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (since_mset >= SINCE_W'(TMRD_EFF)));

  // R5: done lands exactly at the end of the delay and is one cycle wide
  p_done_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_mset == SINCE_W'(TMRD_EFF)));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: busy is low in the done cycle
  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: refused request drives no command and raises err
  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !enc_legal) |=> (cs_n && err && !busy));

endmodule

// File: tb/sdram_mode_loader_bench.sv
module sdram_mode_loader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TRP_M  = 4;
  localparam int TMRD_M = 3;
  localparam int TRP_F  = 2;
  localparam int TMRD_F = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] blen = 3'b001;
  logic it = 1'b0;
  logic [2:0] cl = 3'b011;
  logic dll = 1'b0;

  logic m_cs, m_ras, m_cas, m_we, m_busy, m_done, m_err;
  logic [11:0] m_addr;
  logic [1:0]  m_ba;
  logic f_cs, f_ras, f_cas, f_we, f_busy, f_done, f_err;
  logic [11:0] f_addr;
  logic [1:0]  f_ba;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_mode_loader #(.TRP_CYC(TRP_M), .TMRD_CYC(TMRD_M)) u_sdram_mode_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .req_blen(blen),
    .req_interleave(it), .req_cl(cl), .req_dll_reset(dll),
    .cs_n(m_cs), .ras_n(m_ras), .cas_n(m_cas), .we_n(m_we),
    .addr(m_addr), .ba(m_ba), .busy(m_busy), .done(m_done), .err(m_err)
  );

  sdram_mode_loader #(.TRP_CYC(TRP_F), .TMRD_CYC(TMRD_F)) u_floor (
    .clk(clk), .rst_n(rst_n), .start(start), .req_blen(blen),
    .req_interleave(it), .req_cl(cl), .req_dll_reset(dll),
    .cs_n(f_cs), .ras_n(f_ras), .cas_n(f_cas), .we_n(f_we),
    .addr(f_addr), .ba(f_ba), .busy(f_busy), .done(f_done), .err(f_err)
  );

  function automatic logic [3:0] m_cmd();
    return {m_cs, m_ras, m_cas, m_we};
  endfunction

  function automatic logic [11:0] exp_word(logic [2:0] b, logic i, logic [2:0] c, logic d);
    return {3'b000, d, 1'b0, c, i, b};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic request(logic [2:0] b, logic i, logic [2:0] c, logic d);
    @(negedge clk);
    blen = b; it = i; cl = c; dll = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // R1: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(m_cmd() == 4'hF, "R1 strobes idle in reset", m_cmd(), 4'hF);
    chk(m_addr == 12'h000 && m_ba == 2'b00, "R1 addr/ba zero", {m_ba, m_addr}, 0);
    chk({m_busy, m_done, m_err} == 3'b000, "R1 busy/done/err low", {m_busy, m_done, m_err}, 0);
    rst_n = 1'b1;
  endtask

  // R2 R3 R4 R5 R6 (R7 R11 when poke is set)
  task automatic t_legal(logic [2:0] b, logic i, logic [2:0] c, logic d, bit poke);
    logic [11:0] w;
    w = exp_word(b, i, c, d);
    request(b, i, c, d);
    for (int s = 1; s <= TRP_M + TMRD_M + 4; s++) begin
      if (s == 1) begin
        chk(m_cmd() == 4'b0010, "R2 precharge-all", m_cmd(), 4'b0010);
        chk(m_addr[10] == 1'b1 && m_ba == 2'b00, "R2 all-bank pin", {m_ba, m_addr}, 12'h400);
        chk(m_err == 1'b0, "R10 err cleared by legal start", m_err, 0);
      end else if (s <= TRP_M) begin
        chk(m_cmd() == 4'hF, "R3 idle during precharge wait", m_cmd(), 4'hF);
      end else if (s == TRP_M + 1) begin
        chk(m_cmd() == 4'h0, "R3 mode set after TRP", m_cmd(), 4'h0);
        chk(m_addr == w && m_ba == 2'b00, poke ? "R11 captured word" : "R4 mode word",
            {m_ba, m_addr}, w);
      end else if (s <= TRP_M + TMRD_M) begin
        chk(m_cmd() == 4'hF && !m_done, "R5 idle during set delay", {m_done, m_cmd()}, 4'hF);
      end else if (s == TRP_M + TMRD_M + 1) begin
        chk(m_done == 1'b1, "R5 done after set delay", m_done, 1);
        chk(m_busy == 1'b0, "R6 busy low at done", m_busy, 0);
      end else begin
        chk(m_done == 1'b0 && m_cmd() == 4'hF, poke ? "R7 no restart" : "R5 single done",
            {m_done, m_cmd()}, 4'hF);
      end
      if (s <= TRP_M + TMRD_M)
        chk(m_busy == 1'b1, "R6 busy during sequence", m_busy, 1);
      if (poke && s == 2) begin
        blen = 3'b010; it = ~i; cl = 3'b011; dll = ~d; start = 1'b1;
      end
      if (poke && s == 3) start = 1'b0;
      @(negedge clk);
    end
  endtask

  // R8 R9 R10
  task automatic t_refuse(logic [2:0] b, logic i, logic [2:0] c, string tag);
    request(b, i, c, 1'b0);
    chk(m_err == 1'b1, tag, m_err, 1);
    chk(m_busy == 1'b0, tag, m_busy, 0);
    for (int s = 0; s < 4; s++) begin
      chk(m_cmd() == 4'hF, tag, m_cmd(), 4'hF);
      @(negedge clk);
    end
    chk(m_err == 1'b1, "R10 err holds", m_err, 1);
  endtask

  // R5 floor: TMRD of 1 acts as 2
  task automatic t_floor();
    request(3'b011, 1'b0, 3'b011, 1'b0);
    for (int s = 1; s <= TRP_M + TMRD_M + 3; s++) begin
      if (s == TRP_F + 1)
        chk({f_cs, f_ras, f_cas, f_we} == 4'h0, "R5 floor set cycle", {f_cs, f_ras, f_cas, f_we}, 0);
      if (s == TRP_F + 2)
        chk(f_done == 1'b0, "R5 floor no early done", f_done, 0);
      if (s == TRP_F + 3)
        chk(f_done == 1'b1, "R5 floor done at 2", f_done, 1);
      @(negedge clk);
    end
  endtask

  // R1 R10: reset mid-sequence after an error
  task automatic t_reset_mid();
    request(3'b001, 1'b0, 3'b010, 1'b0);
    request(3'b001, 1'b0, 3'b011, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(m_cmd() == 4'hF && !m_busy, "R1 reset aborts sequence", {m_busy, m_cmd()}, 4'hF);
    chk(m_err == 1'b0, "R10 reset clears err", m_err, 0);
    rst_n = 1'b1;
    repeat (TRP_M + TMRD_M + 2) begin
      @(negedge clk);
      chk(m_cmd() == 4'hF, "R1 stays idle after reset", m_cmd(), 4'hF);
    end
  endtask

  initial begin
    t_reset();
    t_legal(3'b001, 1'b0, 3'b011, 1'b0, 1'b0);
    t_refuse(3'b010, 1'b0, 3'b010, "R8 latency code 010");
    t_legal(3'b010, 1'b1, 3'b011, 1'b1, 1'b0);
    t_refuse(3'b010, 1'b0, 3'b111, "R8 latency code 111");
    t_refuse(3'b000, 1'b0, 3'b011, "R9 burst code 000");
    t_refuse(3'b100, 1'b0, 3'b011, "R9 burst code 100");
    t_refuse(3'b101, 1'b1, 3'b011, "R9 burst code 101");
    t_refuse(3'b110, 1'b0, 3'b011, "R9 burst code 110");
    t_refuse(3'b111, 1'b1, 3'b011, "R9 full page interleave");
    t_legal(3'b111, 1'b0, 3'b011, 1'b1, 1'b0);
    t_legal(3'b011, 1'b0, 3'b011, 1'b0, 1'b1);
    t_floor();
    t_reset_mid();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule